// File: doc/BRIEF.md
# Instruction Line-Fill Buffer Controller

This block sits beside an instruction cache and owns a one-line staging buffer. The buffer is four longwords (16 bytes) in the default build. It keeps the line most recently brought in from the external bus and answers later instruction reads that land on a longword it already holds. The cache's own tag and data arrays, and the choice of which way to replace, live outside this block; it only learns through `tag_hit_i` whether the arrays will answer a request themselves.

When a cacheable fetch misses in both the tag memory and the buffer, the block issues one external fetch. A two-bit line-fill mode, together with the longword offset of the miss, decides whether that fetch is a full line or a single longword. A full line starts at the missed longword and wraps around the line. The requested longword goes back to the requester as soon as it arrives. Every other longword becomes readable the moment it lands, while the rest of the fill is still running. With the cache disabled, or for a non-cacheable fetch, the block passes the request through as a single-longword bus read and leaves the buffer as it was.

A requester holds `fetch_req_i` with a stable address until `rd_ready_o` pulses, or drops it after one cycle when the arrays hit. `bus_req_o` is a one-cycle pulse. Data beats come back on `bus_rvalid_i` in wrap order. A reset clears the enable and the mode, so the cache comes up disabled.

Top module: `ifill_buffer_ctrl`

## Requirements
- R1: After reset, `rd_ready_o` and `bus_req_o` are 0, the enable is cleared and the buffer holds nothing, so the first cacheable fetch produces a single-longword bus read (`bus_line_o`=0).
- R2: While the enable is 0, or when `fetch_cacheable_i`=0, each fetch produces a single-longword bus read and returns its data, and the buffer contents remain readable afterwards.
- R3: A fetch with the cache enabled, `fetch_cacheable_i`=1 and `tag_hit_i`=1 produces neither a bus request nor `rd_ready_o`.
- R4: A cacheable fetch whose longword is valid in the buffer gives `rd_ready_o`=1 with that longword on `rd_data_o` one cycle after it is accepted, with no bus request.
- R5: The fetch size on a cacheable miss follows `cfg_mode_i` as written: 00 gives a full line if the longword offset (address bits [3:2]) is below half the line and a single longword otherwise; 01 always gives a full line; 10 and 11 give a single longword.
- R6: `bus_req_o` is a one-cycle pulse carrying the longword-aligned miss address. A full line returns its beats starting at the missed longword and wrapping. The requested longword appears on `rd_data_o` with `rd_ready_o`=1 in the cycle after its beat.
- R7: During a line fill, a fetch for a longword whose beat has already arrived is served from the buffer without waiting for the fill to end.
- R8: During a line fill, a fetch for a longword of that line that has not yet arrived is held without a bus request and is served once that longword has landed.
- R9: A new fill starts with every longword of the buffer invalid, so a fetch to the previous line, or to a longword of the new line that was not fetched, misses.
- R10: `inval_all_i` marks every buffered longword invalid. Beats of a fill still in progress are not stored after it, but the pending requested longword is still returned.
- R11: `cfg_we_i`=1 loads `cfg_en_i` and `cfg_mode_i`, which govern every fetch accepted from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load enable and mode |
| cfg_en_i | input | 1 | Cache enable value to load |
| cfg_mode_i | input | 2 | Line-fill mode value to load |
| inval_all_i | input | 1 | Invalidate every buffered longword |
| fetch_req_i | input | 1 | Instruction fetch request, held until served |
| fetch_addr_i | input | ADDR_W | Fetch byte address |
| fetch_cacheable_i | input | 1 | Fetch falls in a cacheable region |
| tag_hit_i | input | 1 | Cache tag array hits for this fetch |
| rd_ready_o | output | 1 | Read data valid, one-cycle pulse |
| rd_data_o | output | WORD_W | Read data |
| bus_req_o | output | 1 | External fetch request, one-cycle pulse |
| bus_addr_o | output | ADDR_W | Longword-aligned fetch address |
| bus_line_o | output | 1 | 1 = full line, 0 = single longword |
| bus_rvalid_i | input | 1 | External data beat valid |
| bus_rdata_i | input | WORD_W | External data beat |

## Verification
The bench builds the block with its defaults: 32-bit addresses and longwords, and a four-longword line. With that build the half-line boundary in mode 00 falls between offsets 1 and 2, so both sides of it are reachable. A miss at offset 1 wraps through offset 0 as its last beat, and a miss at offset 3 wraps after its first beat. The small line keeps a fill short enough to place a hit, a stalled read and an invalidate between individual beats.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
  typedef enum logic [0:0] {FSQ_IDLE, FSQ_FILL} fsq_state_e;

  localparam logic [1:0] LNF_HALF = 2'b00;
  localparam logic [1:0] LNF_LINE = 2'b01;
endpackage

// File: rtl/ifb_size_sel.sv
module ifb_size_sel #(
  parameter int WORDS = 4,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             cached_i,
  input  logic [1:0]       mode_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             line_o
);
  import ifb_pkg::*;

  localparam logic [OFF_W-1:0] HALF = OFF_W'(WORDS / 2);

  always_comb begin
    line_o = 1'b0;
    if (cached_i) begin
      case (mode_i)
        LNF_HALF: line_o = (off_i < HALF);
        LNF_LINE: line_o = 1'b1;
        default:  line_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ifb_line_store.sv
module ifb_line_store #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 28,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              inval_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [OFF_W-1:0]  lk_idx_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [TAG_W-1:0]  tag_q;
  logic [WORDS-1:0]  valid_q;
  logic [WORD_W-1:0] data_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tag_q <= '0;
    else if (alloc_i) tag_q <= alloc_tag_i;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     valid_q[w] <= 1'b0;
      else if (inval_i || alloc_i)                     valid_q[w] <= 1'b0;
      else if (wr_i && (wr_idx_i == OFF_W'(w)))        valid_q[w] <= 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     data_q[w] <= '0;
      else if (wr_i && (wr_idx_i == OFF_W'(w)))        data_q[w] <= wr_data_i;
    end
  end

  assign hit_o   = (tag_q == lk_tag_i) && valid_q[lk_idx_i];
  assign rdata_o = data_q[lk_idx_i];

  AST_INVAL_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> (valid_q == '0)); // R10
  AST_ALLOC_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> (valid_q == '0)); // R9
  AST_NO_ALLOC_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_i && wr_i)); // R9
endmodule

// File: rtl/ifb_fill_seq.sv
module ifb_fill_seq #(
  parameter int WORDS = 4,
  localparam int OFF_W = $clog2(WORDS),
  localparam int CNT_W = $clog2(WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_line_i,
  input  logic             start_store_i,
  input  logic [OFF_W-1:0] start_off_i,
  input  logic             inval_i,
  input  logic             beat_i,
  output logic             busy_o,
  output logic             pending_o,
  output logic             wr_o,
  output logic [OFF_W-1:0] wr_idx_o,
  output logic             deliver_o
);
  import ifb_pkg::*;

  fsq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, last_q;
  logic [OFF_W-1:0] off_q;
  logic             pend_q, store_q;
  logic             take;

  assign busy_o    = (state_q == FSQ_FILL);
  assign pending_o = pend_q;
  assign take      = busy_o && beat_i;
  assign wr_o      = take && store_q;
  assign deliver_o = take && pend_q;
  assign wr_idx_o  = off_q + cnt_q[OFF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FSQ_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
      off_q   <= '0;
      pend_q  <= 1'b0;
      store_q <= 1'b0;
    end else if (start_i) begin
      state_q <= FSQ_FILL;
      cnt_q   <= '0;
      last_q  <= start_line_i ? CNT_W'(WORDS - 1) : '0;
      off_q   <= start_off_i;
      pend_q  <= 1'b1;
      store_q <= start_store_i;
    end else if (busy_o) begin
      if (inval_i) store_q <= 1'b0;
      if (beat_i) begin
        pend_q <= 1'b0;
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == last_q) state_q <= FSQ_IDLE;
      end
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R6
  AST_BEAT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q <= last_q)); // R6
  AST_DELIVER_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_o |-> (cnt_q == '0)); // R6
  AST_INVAL_STOPS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && inval_i && !start_i) |=> !wr_o); // R10
endmodule

// File: rtl/ifill_buffer_ctrl.sv
module ifill_buffer_ctrl #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - OFF_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              inval_all_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              fetch_cacheable_i,
  input  logic              tag_hit_i,
  output logic              rd_ready_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_line_o,
  input  logic              bus_rvalid_i,
  input  logic [WORD_W-1:0] bus_rdata_i
);
  logic             en_q;
  logic [1:0]       mode_q;
  logic [TAG_W-1:0] fa_tag;
  logic [OFF_W-1:0] fa_off;
  logic             cached, look, array_hit, buf_hit, may_serve, start, line_sel;
  logic             st_hit, seq_busy, seq_pend, seq_wr, seq_deliver;
  logic [OFF_W-1:0] seq_idx;
  logic [WORD_W-1:0] st_rdata;
  logic             rd_ready_q, bus_req_q, bus_line_q;
  logic [WORD_W-1:0] rd_data_q;
  logic [ADDR_W-1:0] bus_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= 2'b00;
    end else if (cfg_we_i) begin
      en_q   <= cfg_en_i;
      mode_q <= cfg_mode_i;
    end
  end

  assign fa_tag    = fetch_addr_i[ADDR_W-1 -: TAG_W];
  assign fa_off    = fetch_addr_i[BYTE_W +: OFF_W];
  assign cached    = en_q && fetch_cacheable_i;
  // one request per rd_ready pulse; invalidate cycle defers lookup
  assign look      = fetch_req_i && !rd_ready_q && !inval_all_i;
  assign array_hit = cached && tag_hit_i;
  assign buf_hit   = cached && !tag_hit_i && st_hit;
  assign may_serve = look && !seq_pend && buf_hit;
  assign start     = look && !seq_busy && !array_hit && !buf_hit;

  ifb_size_sel #(.WORDS(WORDS)) u_size (
    .cached_i (cached),
    .mode_i   (mode_q),
    .off_i    (fa_off),
    .line_o   (line_sel)
  );

  ifb_line_store #(.WORDS(WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (start && cached),
    .alloc_tag_i (fa_tag),
    .wr_i        (seq_wr),
    .wr_idx_i    (seq_idx),
    .wr_data_i   (bus_rdata_i),
    .inval_i     (inval_all_i),
    .lk_tag_i    (fa_tag),
    .lk_idx_i    (fa_off),
    .hit_o       (st_hit),
    .rdata_o     (st_rdata)
  );

  ifb_fill_seq #(.WORDS(WORDS)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .start_line_i  (line_sel),
    .start_store_i (cached),
    .start_off_i   (fa_off),
    .inval_i       (inval_all_i),
    .beat_i        (bus_rvalid_i),
    .busy_o        (seq_busy),
    .pending_o     (seq_pend),
    .wr_o          (seq_wr),
    .wr_idx_o      (seq_idx),
    .deliver_o     (seq_deliver)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ready_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_ready_q <= may_serve || seq_deliver;
      if (seq_deliver)    rd_data_q <= bus_rdata_i;
      else if (may_serve) rd_data_q <= st_rdata;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_req_q  <= 1'b0;
      bus_addr_q <= '0;
      bus_line_q <= 1'b0;
    end else begin
      bus_req_q <= start;
      if (start) begin
        bus_addr_q <= {fetch_addr_i[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
        bus_line_q <= line_sel;
      end
    end
  end

  assign rd_ready_o = rd_ready_q;
  assign rd_data_o  = rd_data_q;
  assign bus_req_o  = bus_req_q;
  assign bus_addr_o = bus_addr_q;
  assign bus_line_o = bus_line_q;

  AST_BUS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |=> !bus_req_o); // R6
  AST_BUS_HAS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> seq_busy); // R6
  AST_LINE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_line_o) |-> $past(en_q)); // R2
  AST_TAGHIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && !rd_ready_o && !inval_all_i && !seq_busy && en_q &&
     fetch_cacheable_i && tag_hit_i) |=> (!bus_req_o && !rd_ready_o)); // R3
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ready_o |=> !rd_ready_o); // R4
  AST_SRC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(may_serve && seq_deliver)); // R7
endmodule

// File: tb/ifill_buffer_ctrl_bench.sv
module ifill_buffer_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0, cfg_en = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        inval_all = 1'b0;
  logic        fetch_req = 1'b0, fetch_cacheable = 1'b0, tag_hit = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        rd_ready, bus_req, bus_line;
  logic [31:0] rd_data, bus_addr;
  logic        bus_rvalid = 1'b0;
  logic [31:0] bus_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ifill_buffer_ctrl u_ifill_buffer_ctrl (
    .clk_i (clk), .rst_ni (rst_ni),
    .cfg_we_i (cfg_we), .cfg_en_i (cfg_en), .cfg_mode_i (cfg_mode),
    .inval_all_i (inval_all),
    .fetch_req_i (fetch_req), .fetch_addr_i (fetch_addr),
    .fetch_cacheable_i (fetch_cacheable), .tag_hit_i (tag_hit),
    .rd_ready_o (rd_ready), .rd_data_o (rd_data),
    .bus_req_o (bus_req), .bus_addr_o (bus_addr), .bus_line_o (bus_line),
    .bus_rvalid_i (bus_rvalid), .bus_rdata_i (bus_rdata)
  );

  function automatic logic [31:0] md(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic en, input logic [1:0] mode);
    cfg_en = en; cfg_mode = mode; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic inval();
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
  endtask

  task automatic issue(input logic [31:0] a, input logic c, input logic th);
    fetch_addr = a; fetch_cacheable = c; tag_hit = th; fetch_req = 1'b1;
  endtask

  task automatic beat(input logic [31:0] a);
    bus_rvalid = 1'b1; bus_rdata = md(a);
    @(negedge clk);
    bus_rvalid = 1'b0;
  endtask

  // miss path: bus request, first beat returned, remaining beats wrap
  task automatic do_miss(input logic [31:0] a, input logic c, input logic line, input string tag);
    logic [31:0] base;
    logic [1:0]  off;
    base = a & ~32'hF;
    off  = a[3:2];
    issue(a, c, 1'b0);
    @(negedge clk);
    chk({tag, " bus_req"}, 32'(bus_req), 32'd1);
    chk({tag, " bus_line"}, 32'(bus_line), 32'(line));
    chk({tag, " bus_addr"}, bus_addr, {a[31:2], 2'b00});
    beat(a);
    chk({tag, " R6 bus_req pulse"}, 32'(bus_req), 32'd0);
    chk({tag, " rd_ready"}, 32'(rd_ready), 32'd1);
    chk({tag, " rd_data"}, rd_data, md(a));
    fetch_req = 1'b0;
    if (line)
      for (int k = 1; k < 4; k++) beat(base | (32'(2'(off + 2'(k))) << 2));
    @(negedge clk);
  endtask

  task automatic serve(input logic [31:0] a, input string tag);
    issue(a, 1'b1, 1'b0);
    @(negedge clk);
    chk({tag, " hit rd_ready"}, 32'(rd_ready), 32'd1);
    chk({tag, " hit rd_data"}, rd_data, md(a));
    chk({tag, " hit no bus_req"}, 32'(bus_req), 32'd0);
    fetch_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rd_ready after reset", 32'(rd_ready), 32'd0);
    chk("R1 bus_req after reset", 32'(bus_req), 32'd0);
    do_miss(32'h100, 1'b1, 1'b0, "R1 disabled single");
    inval();
  endtask

  task automatic t_line_wrap();
    cfg(1'b1, 2'b00);
    do_miss(32'h204, 1'b1, 1'b1, "R5 R6 mode00 off1 line");
    serve(32'h200, "R6 wrapped word");
    serve(32'h20C, "R4");
    serve(32'h204, "R4");
  endtask

  task automatic t_size_modes();
    do_miss(32'h308, 1'b1, 1'b0, "R5 mode00 off2 single");
    do_miss(32'h30C, 1'b1, 1'b0, "R9 unfetched word misses");
    do_miss(32'h200, 1'b1, 1'b1, "R9 old line replaced");
    cfg(1'b1, 2'b01);
    do_miss(32'h40C, 1'b1, 1'b1, "R5 R11 mode01 off3 line");
    serve(32'h408, "R6 wrap after off3");
    cfg(1'b1, 2'b10);
    do_miss(32'h500, 1'b1, 1'b0, "R5 R11 mode10 single");
    cfg(1'b1, 2'b11);
    do_miss(32'h600, 1'b1, 1'b0, "R5 mode11 single");
  endtask

  task automatic t_bypass();
    cfg(1'b1, 2'b01);
    do_miss(32'h204, 1'b1, 1'b1, "R2 setup line");
    do_miss(32'h208, 1'b0, 1'b0, "R2 noncacheable single");
    serve(32'h208, "R2 buffer kept after bypass");
    cfg(1'b0, 2'b01);
    do_miss(32'h20C, 1'b1, 1'b0, "R2 R11 disabled single");
    cfg(1'b1, 2'b01);
    serve(32'h20C, "R2 buffer kept while disabled");
  endtask

  task automatic t_tag_hit();
    issue(32'h900, 1'b1, 1'b1);
    @(negedge clk);
    chk("R3 no bus_req", 32'(bus_req), 32'd0);
    chk("R3 no rd_ready", 32'(rd_ready), 32'd0);
    @(negedge clk);
    chk("R3 still no bus_req", 32'(bus_req), 32'd0);
    chk("R3 still no rd_ready", 32'(rd_ready), 32'd0);
    fetch_req = 1'b0; tag_hit = 1'b0;
    @(negedge clk);
    serve(32'h200, "R3 buffer untouched");
  endtask

  task automatic t_partial();
    bit got, saw_bus;
    issue(32'h700, 1'b1, 1'b0);
    @(negedge clk);
    chk("R7 fill bus_req", 32'(bus_req), 32'd1);
    beat(32'h700);
    chk("R7 first word ready", 32'(rd_ready), 32'd1);
    fetch_req = 1'b0;
    beat(32'h704);
    issue(32'h704, 1'b1, 1'b0);
    @(negedge clk);
    chk("R7 arrived word rd_ready mid-fill", 32'(rd_ready), 32'd1);
    chk("R7 arrived word data", rd_data, md(32'h704));
    chk("R7 no bus_req", 32'(bus_req), 32'd0);
    fetch_req = 1'b0;
    @(negedge clk);
    issue(32'h70C, 1'b1, 1'b0);
    @(negedge clk);
    chk("R8 pending word stalls", 32'(rd_ready), 32'd0);
    beat(32'h708);
    chk("R8 still stalled", 32'(rd_ready), 32'd0);
    beat(32'h70C);
    got = 1'b0; saw_bus = 1'b0;
    for (int i = 0; i < 4 && !got; i++) begin
      if (bus_req) saw_bus = 1'b1;
      if (rd_ready) begin
        got = 1'b1;
        chk("R8 late word data", rd_data, md(32'h70C));
      end else @(negedge clk);
    end
    chk("R8 late word served", 32'(got), 32'd1);
    chk("R8 no bus_req", 32'(saw_bus), 32'd0);
    fetch_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_inval();
    inval();
    do_miss(32'h704, 1'b1, 1'b1, "R10 after invalidate");
    issue(32'h800, 1'b1, 1'b0);
    @(negedge clk);
    chk("R10 fill bus_req", 32'(bus_req), 32'd1);
    inval_all = 1'b1;
    beat(32'h800);
    inval_all = 1'b0;
    chk("R10 pending word still returned", 32'(rd_ready), 32'd1);
    chk("R10 pending word data", rd_data, md(32'h800));
    fetch_req = 1'b0;
    beat(32'h804);
    beat(32'h808);
    beat(32'h80C);
    @(negedge clk);
    do_miss(32'h80C, 1'b1, 1'b1, "R10 later beats not stored");
  endtask

  task automatic t_reset_again();
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 rd_ready after second reset", 32'(rd_ready), 32'd0);
    do_miss(32'h80C, 1'b1, 1'b0, "R1 reset disables");
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<%0d cycles", WDOG_CYC, WDOG_CYC);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_line_wrap();
    t_size_modes();
    t_bypass();
    t_tag_hit();
    t_partial();
    t_inval();
    t_reset_again();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule